// File: doc/BRIEF.md
# SHA-256 Chaining Compression Core

This block runs the SHA-256 compression function over one fully padded 512-bit message block at a time and holds the 256-bit chaining hash between blocks. A start command seeds the chaining hash with the standard initial values and then compresses the block. A continue command compresses the block on top of whatever chaining hash is currently held. Padding and length encoding are the caller's job.

Each of the eight 32-bit chaining words can be overwritten from outside while the core is idle. A strobe vector picks the word and one shared data bus carries the value. Software can therefore park a partly hashed message, work on another one, and later put the saved context back before continuing. The result is the same as if the blocks had been processed back to back.

The core executes one round per clock over 64 rounds. It then spends one more cycle folding the working variables into the chaining words. While it works, ready is low and all commands and word writes are dropped.

Top module: `sha256_chain_core`

## Requirements
- R1: After reset, ready_o is 1, digest_valid_o is 0 and digest_o is all zeros.
- R2: A start_i pulse while ready loads the standard initial hash values and compresses block_i. Block word 0 sits at bits 511:480. The digest of the padded "abc" block is BA7816BF8F01CFEA414140DE5DAE2223B00361A396177A9CB410FF61F20015AD, and the digest of the padded empty message is E3B0C44298FC1C149AFBF4C8996FB92427AE41E4649B934CA495991B7852B855.
- R3: A cont_i pulse while ready compresses block_i starting from the chaining hash currently held, so two-block messages hash correctly.
- R4: While ready and with no command, hw_we_i[i] = 1 writes hw_data_i into chaining word i. Word i occupies digest_o bits 255-32i down to 224-32i, and the new value is visible on digest_o one cycle later.
- R5: Writing the first-block digest into the eight words and then issuing continue on the second block gives the same digest as processing both blocks in sequence.
- R6: Ready drops in the cycle after a command is accepted. It rises again, together with digest_valid_o, exactly 65 clock edges after the accepting edge.
- R7: digest_valid_o is cleared when a command is accepted. It is only ever high while ready_o is high.
- R8: Commands and word writes that arrive while the core is busy are ignored.
- R9: If start_i and cont_i are both high in the accepting cycle, start wins.
- R10: A word write in the same cycle as an accepted command is ignored.
- R11: While busy, digest_o holds steady. After a start it shows the initial hash values until the final fold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Single-cycle command: new message from initial values |
| cont_i | input | 1 | Single-cycle command: continue from current chaining hash |
| block_i | input | 512 | Padded message block, word 0 in bits 511:480 |
| hw_data_i | input | 32 | Shared write data for chaining words |
| hw_we_i | input | 8 | Per-word write strobes, bit i selects word i |
| ready_o | output | 1 | Core idle and able to accept a command or write |
| digest_o | output | 256 | Chaining hash, word 0 in bits 255:224 |
| digest_valid_o | output | 1 | Digest of the last command is complete |

## Verification
A command is driven before the accepting edge, and the bench samples on falling edges after that. Ready must be low at the first falling edge after the accepting edge, and high with digest-valid at the 66th. The bench counts falling edges exactly rather than polling loosely, so an off-by-one in the round counter or fold cycle shows up as a latency mismatch. A word write is checked at the falling edge one cycle after its strobe. Stimuli injected during the busy window are followed by a full-latency check and a digest compare against a known vector.

// File: rtl/sha_chain_pkg.sv
package sha_chain_pkg;

  localparam int WORD_W      = 32;
  localparam int NUM_WORDS   = 8;
  localparam int BLOCK_WORDS = 16;
  localparam int ROUNDS      = 64;
  localparam int BLOCK_W     = WORD_W * BLOCK_WORDS;
  localparam int DIGEST_W    = WORD_W * NUM_WORDS;
  localparam int CNT_W       = $clog2(ROUNDS);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NUM_WORDS-1:0][WORD_W-1:0] wstate_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROUND = 2'd1,
    ST_FOLD  = 2'd2
  } ctl_e;

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t bsig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t bsig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t ssig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t ssig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  // standard initial chaining values, word index 0..7
  function automatic word_t init_word(input int i);
    case (i)
      0:       return 32'h6a09e667;
      1:       return 32'hbb67ae85;
      2:       return 32'h3c6ef372;
      3:       return 32'ha54ff53a;
      4:       return 32'h510e527f;
      5:       return 32'h9b05688c;
      6:       return 32'h1f83d9ab;
      default: return 32'h5be0cd19;
    endcase
  endfunction

endpackage

// File: rtl/sha_round_const.sv
module sha_round_const
  import sha_chain_pkg::*;
(
  input  logic [CNT_W-1:0] idx_i,
  output word_t            k_o
);

  always_comb begin
    case (int'(idx_i))
      0:  k_o = 32'h428a2f98;  1:  k_o = 32'h71374491;
      2:  k_o = 32'hb5c0fbcf;  3:  k_o = 32'he9b5dba5;
      4:  k_o = 32'h3956c25b;  5:  k_o = 32'h59f111f1;
      6:  k_o = 32'h923f82a4;  7:  k_o = 32'hab1c5ed5;
      8:  k_o = 32'hd807aa98;  9:  k_o = 32'h12835b01;
      10: k_o = 32'h243185be;  11: k_o = 32'h550c7dc3;
      12: k_o = 32'h72be5d74;  13: k_o = 32'h80deb1fe;
      14: k_o = 32'h9bdc06a7;  15: k_o = 32'hc19bf174;
      16: k_o = 32'he49b69c1;  17: k_o = 32'hefbe4786;
      18: k_o = 32'h0fc19dc6;  19: k_o = 32'h240ca1cc;
      20: k_o = 32'h2de92c6f;  21: k_o = 32'h4a7484aa;
      22: k_o = 32'h5cb0a9dc;  23: k_o = 32'h76f988da;
      24: k_o = 32'h983e5152;  25: k_o = 32'ha831c66d;
      26: k_o = 32'hb00327c8;  27: k_o = 32'hbf597fc7;
      28: k_o = 32'hc6e00bf3;  29: k_o = 32'hd5a79147;
      30: k_o = 32'h06ca6351;  31: k_o = 32'h14292967;
      32: k_o = 32'h27b70a85;  33: k_o = 32'h2e1b2138;
      34: k_o = 32'h4d2c6dfc;  35: k_o = 32'h53380d13;
      36: k_o = 32'h650a7354;  37: k_o = 32'h766a0abb;
      38: k_o = 32'h81c2c92e;  39: k_o = 32'h92722c85;
      40: k_o = 32'ha2bfe8a1;  41: k_o = 32'ha81a664b;
      42: k_o = 32'hc24b8b70;  43: k_o = 32'hc76c51a3;
      44: k_o = 32'hd192e819;  45: k_o = 32'hd6990624;
      46: k_o = 32'hf40e3585;  47: k_o = 32'h106aa070;
      48: k_o = 32'h19a4c116;  49: k_o = 32'h1e376c08;
      50: k_o = 32'h2748774c;  51: k_o = 32'h34b0bcb5;
      52: k_o = 32'h391c0cb3;  53: k_o = 32'h4ed8aa4a;
      54: k_o = 32'h5b9cca4f;  55: k_o = 32'h682e6ff3;
      56: k_o = 32'h748f82ee;  57: k_o = 32'h78a5636f;
      58: k_o = 32'h84c87814;  59: k_o = 32'h8cc70208;
      60: k_o = 32'h90befffa;  61: k_o = 32'ha4506ceb;
      62: k_o = 32'hbef9a3f7;  63: k_o = 32'hc67178f2;
      default: k_o = '0;
    endcase
  end

endmodule

// File: rtl/sha_msg_window.sv
module sha_msg_window
  import sha_chain_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [BLOCK_W-1:0] block_i,
  output word_t              w_o
);

  // taps of the schedule recurrence relative to the oldest word
  localparam int TAP_S0  = 1;
  localparam int TAP_ADD = 9;
  localparam int TAP_S1  = 14;
  localparam int LAST    = BLOCK_WORDS - 1;

  typedef logic [BLOCK_WORDS-1:0][WORD_W-1:0] win_t;

  win_t  win_q;
  win_t  win_d;
  logic  win_en;
  word_t w_new;

  always_comb begin
    w_new = ssig1(win_q[TAP_S1]) + win_q[TAP_ADD] + ssig0(win_q[TAP_S0]) + win_q[0];
  end

  always_comb begin
    win_en = load_i | shift_i;
    win_d  = win_q;
    if (load_i) begin
      for (int j = 0; j < BLOCK_WORDS; j++) begin
        win_d[j] = block_i[BLOCK_W-1-j*WORD_W -: WORD_W];
      end
    end else if (shift_i) begin
      for (int j = 0; j < LAST; j++) begin
        win_d[j] = win_q[j+1];
      end
      win_d[LAST] = w_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (win_en) begin
      win_q <= win_d;
    end
  end

  assign w_o = win_q[0];

endmodule

// File: rtl/sha_round_fn.sv
module sha_round_fn
  import sha_chain_pkg::*;
(
  input  wstate_t work_i,
  input  word_t   k_i,
  input  word_t   w_i,
  output wstate_t work_o
);

  word_t a, b, c, d, e, f, g, h;
  word_t t1, t2;

  always_comb begin
    a = work_i[0]; b = work_i[1]; c = work_i[2]; d = work_i[3];
    e = work_i[4]; f = work_i[5]; g = work_i[6]; h = work_i[7];
    t1 = h + bsig1(e) + ((e & f) ^ (~e & g)) + k_i + w_i;
    t2 = bsig0(a) + ((a & b) ^ (a & c) ^ (b & c));
    work_o[0] = t1 + t2;
    work_o[1] = a;
    work_o[2] = b;
    work_o[3] = c;
    work_o[4] = d + t1;
    work_o[5] = e;
    work_o[6] = f;
    work_o[7] = g;
  end

endmodule

// File: rtl/sha256_chain_core.sv
module sha256_chain_core
  import sha_chain_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 cont_i,
  input  logic [BLOCK_W-1:0]   block_i,
  input  logic [WORD_W-1:0]    hw_data_i,
  input  logic [NUM_WORDS-1:0] hw_we_i,
  output logic                 ready_o,
  output logic [DIGEST_W-1:0]  digest_o,
  output logic                 digest_valid_o
);

  localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ctl_e                 ctl_q, ctl_d;
  logic [CNT_W-1:0]     rnd_q, rnd_d;
  logic                 rnd_en;
  logic                 valid_q, valid_d;
  wstate_t              work_q, work_d, work_rnd;
  logic                 work_en;
  wstate_t              hash_q, hash_d;
  logic [NUM_WORDS-1:0] hash_en;
  logic                 win_load, win_shift;
  logic                 accept;
  word_t                k_cur, w_cur;

  sha_round_const u_kc (
    .idx_i (rnd_q),
    .k_o   (k_cur)
  );

  sha_msg_window u_win (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .load_i  (win_load),
    .shift_i (win_shift),
    .block_i (block_i),
    .w_o     (w_cur)
  );

  sha_round_fn u_rnd (
    .work_i (work_q),
    .k_i    (k_cur),
    .w_i    (w_cur),
    .work_o (work_rnd)
  );

  assign accept = (ctl_q == ST_IDLE) && (start_i || cont_i);

  always_comb begin
    ctl_d     = ctl_q;
    rnd_d     = rnd_q;
    rnd_en    = 1'b0;
    valid_d   = valid_q;
    work_d    = work_q;
    work_en   = 1'b0;
    hash_d    = hash_q;
    hash_en   = '0;
    win_load  = 1'b0;
    win_shift = 1'b0;
    case (ctl_q)
      ST_IDLE: begin
        if (accept) begin
          ctl_d    = ST_ROUND;
          rnd_d    = '0;
          rnd_en   = 1'b1;
          valid_d  = 1'b0;
          win_load = 1'b1;
          work_en  = 1'b1;
          for (int i = 0; i < NUM_WORDS; i++) begin
            if (start_i) begin
              hash_d[i]  = init_word(i);
              hash_en[i] = 1'b1;
              work_d[i]  = init_word(i);
            end else begin
              work_d[i]  = hash_q[i];
            end
          end
        end else begin
          for (int i = 0; i < NUM_WORDS; i++) begin
            if (hw_we_i[i]) begin
              hash_d[i]  = hw_data_i;
              hash_en[i] = 1'b1;
            end
          end
        end
      end
      ST_ROUND: begin
        work_d    = work_rnd;
        work_en   = 1'b1;
        win_shift = 1'b1;
        rnd_d     = rnd_q + 1'b1;
        rnd_en    = 1'b1;
        if (rnd_q == LAST_RND) begin
          ctl_d = ST_FOLD;
        end
      end
      ST_FOLD: begin
        for (int i = 0; i < NUM_WORDS; i++) begin
          hash_d[i]  = hash_q[i] + work_q[i];
          hash_en[i] = 1'b1;
        end
        valid_d = 1'b1;
        ctl_d   = ST_IDLE;
      end
      default: ctl_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      ctl_q   <= ST_IDLE;
      valid_q <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      rnd_q <= '0;
    end else if (rnd_en) begin
      rnd_q <= rnd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      work_q <= '0;
    end else if (work_en) begin
      work_q <= work_d;
    end
  end

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_hash
    always_ff @(posedge clk or negedge rst_sync_q) begin
      if (!rst_sync_q) begin
        hash_q[gi] <= '0;
      end else if (hash_en[gi]) begin
        hash_q[gi] <= hash_d[gi];
      end
    end
    assign digest_o[DIGEST_W-1-gi*WORD_W -: WORD_W] = hash_q[gi];
  end

  assign ready_o        = (ctl_q == ST_IDLE);
  assign digest_valid_o = valid_q;

endmodule

// File: rtl/sha_chain_chk.sv
module sha_chain_chk
  import sha_chain_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 cont_i,
  input logic [WORD_W-1:0]    hw_data_i,
  input logic [NUM_WORDS-1:0] hw_we_i,
  input logic                 ready_o,
  input logic [DIGEST_W-1:0]  digest_o,
  input logic                 digest_valid_o
);

  localparam int BUSY_CYC = ROUNDS + 1;
  localparam int BC_W     = $clog2(BUSY_CYC + 2);

  logic [BC_W-1:0] busy_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt_q <= '0;
    end else if (!ready_o) begin
      busy_cnt_q <= busy_cnt_q + 1'b1;
    end else begin
      busy_cnt_q <= '0;
    end
  end

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (busy_cnt_q == BC_W'(BUSY_CYC)));

  // R6
  ready_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_o) |-> $past(start_i || cont_i));

  // R7
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && (start_i || cont_i)) |=> (!ready_o && !digest_valid_o));

  // R7
  valid_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digest_valid_o |-> ready_o);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && $past(!ready_o)) |-> $stable(digest_o));

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_wr
    // R4
    word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !start_i && !cont_i && hw_we_i[gi])
        |=> (digest_o[DIGEST_W-1-gi*WORD_W -: WORD_W] == $past(hw_data_i)));
  end

endmodule

bind sha256_chain_core sha_chain_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_q),
  .start_i        (start_i),
  .cont_i         (cont_i),
  .hw_data_i      (hw_data_i),
  .hw_we_i        (hw_we_i),
  .ready_o        (ready_o),
  .digest_o       (digest_o),
  .digest_valid_o (digest_valid_o)
);

// File: tb/tb_sha256_chain_core.sv
module tb_sha256_chain_core;

  localparam int DONE_LAT = 66;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic         cont_i;
  logic [511:0] block_i;
  logic [31:0]  hw_data_i;
  logic [7:0]   hw_we_i;
  logic         ready_o;
  logic [255:0] digest_o;
  logic         digest_valid_o;

  int n_chk;
  int n_fail;
  bit timed_out;

  localparam logic [511:0] BLK_ABC   = {32'h61626380, 416'h0, 64'h18};
  localparam logic [511:0] BLK_EMPTY = {32'h80000000, 480'h0};
  localparam logic [511:0] BLK_TWO_A = {448'h6162636462636465636465666465666765666768666768696768696a68696a6b696a6b6c6a6b6c6d6b6c6d6e6c6d6e6f6d6e6f706e6f7071, 64'h8000000000000000};
  localparam logic [511:0] BLK_TWO_B = {448'h0, 64'h1c0};
  localparam logic [255:0] DG_ABC    = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
  localparam logic [255:0] DG_EMPTY  = 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;
  localparam logic [255:0] DG_TWO_A  = 256'h85e655d6417a17953363376a624cde5c76e09589cac5f811cc4b32c1f20e533a;
  localparam logic [255:0] DG_TWO_B  = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;
  localparam logic [255:0] IV_ALL    = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;

  sha256_chain_core dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .cont_i         (cont_i),
    .block_i        (block_i),
    .hw_data_i      (hw_data_i),
    .hw_we_i        (hw_we_i),
    .ready_o        (ready_o),
    .digest_o       (digest_o),
    .digest_valid_o (digest_valid_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string what, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // drive a command for one accepting edge; returns at falling edge 1
  task automatic issue(input bit st, input bit ct, input logic [511:0] blk);
    @(negedge clk);
    start_i = st;
    cont_i  = ct;
    block_i = blk;
    @(negedge clk);
    start_i = 1'b0;
    cont_i  = 1'b0;
  endtask

  task automatic wait_done(inout int lat);
    while (!ready_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_cmd(input bit st, input bit ct, input logic [511:0] blk, output int lat);
    issue(st, ct, blk);
    lat = 1;
    chk(!ready_o, "R6 ready low after accept", 256'(ready_o), 256'd0);
    wait_done(lat);
  endtask

  task automatic write_word(input int idx, input logic [31:0] val);
    @(negedge clk);
    hw_we_i   = 8'(1 << idx);
    hw_data_i = val;
    @(negedge clk);
    hw_we_i   = '0;
    chk(digest_o[255-32*idx -: 32] == val, "R4 word write visible",
        256'(digest_o[255-32*idx -: 32]), 256'(val));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ready_o == 1'b1, "R1 ready after reset", 256'(ready_o), 256'd1);
    chk(digest_valid_o == 1'b0, "R1 valid after reset", 256'(digest_valid_o), 256'd0);
    chk(digest_o == '0, "R1 digest after reset", digest_o, 256'd0);
  endtask

  task automatic t_abc();
    int lat;
    run_cmd(1'b1, 1'b0, BLK_ABC, lat);
    chk(lat == DONE_LAT, "R6 latency abc", 256'(lat), 256'(DONE_LAT));
    chk(digest_valid_o, "R7 valid at done", 256'(digest_valid_o), 256'd1);
    chk(digest_o == DG_ABC, "R2 abc digest", digest_o, DG_ABC);
  endtask

  task automatic t_valid_clear();
    int lat;
    issue(1'b0, 1'b1, BLK_EMPTY);
    chk(!digest_valid_o, "R7 valid cleared on accept", 256'(digest_valid_o), 256'd0);
    lat = 1;
    wait_done(lat);
    chk(lat == DONE_LAT, "R6 latency continue", 256'(lat), 256'(DONE_LAT));
  endtask

  task automatic t_two_block();
    int lat;
    run_cmd(1'b1, 1'b0, BLK_TWO_A, lat);
    chk(digest_o == DG_TWO_A, "R2 first block digest", digest_o, DG_TWO_A);
    run_cmd(1'b0, 1'b1, BLK_TWO_B, lat);
    chk(digest_o == DG_TWO_B, "R3 chained second block", digest_o, DG_TWO_B);
  endtask

  task automatic t_restore();
    int lat;
    run_cmd(1'b1, 1'b0, BLK_EMPTY, lat);
    chk(digest_o == DG_EMPTY, "R2 empty message digest", digest_o, DG_EMPTY);
    for (int i = 0; i < 8; i++) begin
      write_word(i, DG_TWO_A[255-32*i -: 32]);
    end
    chk(digest_o == DG_TWO_A, "R4 all words restored", digest_o, DG_TWO_A);
    run_cmd(1'b0, 1'b1, BLK_TWO_B, lat);
    chk(digest_o == DG_TWO_B, "R5 restored context continue", digest_o, DG_TWO_B);
  endtask

  task automatic t_busy_ignore();
    int lat;
    issue(1'b1, 1'b0, BLK_ABC);
    lat = 1;
    chk(digest_o == IV_ALL, "R11 initial values during busy", digest_o, IV_ALL);
    @(negedge clk);
    lat++;
    hw_we_i   = 8'hff;
    hw_data_i = 32'hdeadbeef;
    start_i   = 1'b1;
    cont_i    = 1'b1;
    block_i   = BLK_EMPTY;
    @(negedge clk);
    lat++;
    hw_we_i = '0;
    start_i = 1'b0;
    cont_i  = 1'b0;
    block_i = BLK_ABC;
    @(negedge clk);
    lat++;
    chk(digest_o == IV_ALL, "R8 write during busy ignored", digest_o, IV_ALL);
    wait_done(lat);
    chk(lat == DONE_LAT, "R8 busy command does not restart", 256'(lat), 256'(DONE_LAT));
    chk(digest_o == DG_ABC, "R8 digest unaffected by busy stimulus", digest_o, DG_ABC);
  endtask

  task automatic t_both_cmds();
    int lat;
    run_cmd(1'b1, 1'b1, BLK_EMPTY, lat);
    chk(digest_o == DG_EMPTY, "R9 start wins over continue", digest_o, DG_EMPTY);
  endtask

  task automatic t_write_with_cmd();
    int lat;
    for (int i = 0; i < 8; i++) begin
      write_word(i, DG_TWO_A[255-32*i -: 32]);
    end
    @(negedge clk);
    cont_i    = 1'b1;
    block_i   = BLK_TWO_B;
    hw_we_i   = 8'hff;
    hw_data_i = 32'h0badf00d;
    @(negedge clk);
    cont_i  = 1'b0;
    hw_we_i = '0;
    lat = 1;
    wait_done(lat);
    chk(digest_o == DG_TWO_B, "R10 write with command ignored", digest_o, DG_TWO_B);
  endtask

  initial begin
    n_chk     = 0;
    n_fail    = 0;
    timed_out = 1'b0;
    rst_n     = 1'b0;
    start_i   = 1'b0;
    cont_i    = 1'b0;
    block_i   = '0;
    hw_data_i = '0;
    hw_we_i   = '0;
    fork
      begin
        t_reset();
        t_abc();
        t_valid_clear();
        t_two_block();
        t_restore();
        t_busy_ignore();
        t_both_cmds();
        t_write_with_cmd();
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule